// File: doc/BRIEF.md
# Chaotic map keystream cipher

This core is a byte-wide stream cipher. Its keystream comes from a skew tent map evaluated in fixed point: a state fraction `x` and a breakpoint fraction `g` give the next state `x/g` on the rising side (`x <= g`) and `(1-x)/(1-g)` on the falling side (`x > g`). The core never divides. Both reciprocals are computed outside and loaded with the key, and each step does one multiply. To stretch the period of the finite-precision map, the least significant bit of every new state is XORed with the output bit of a maximal-length Fibonacci LFSR before that state is fed back. The low byte of each perturbed state is the keystream byte for one message byte.

A key load sets the breakpoint, the starting state, the two reciprocals and the LFSR seed. Message bytes then enter through a valid/ready input. Each accepted byte leaves as `data ^ keystream` through a valid/ready output one cycle later. Encryption and decryption are the same operation, so a receiver loaded with the same key recovers the plaintext. With the output always ready, the core takes one byte per clock. When the output is blocked it holds all state.

Top module: `chaos_stream_cipher`

## Requirements
- R1: Rising side. When `x <= g`, the raw next state is `floor(x * rcp_rise / 2^XW)`. Here `rcp_rise` is an unsigned value with XW fraction bits and IW integer bits.
- R2: Falling side. When `x > g`, the raw next state is `floor((2^XW - x) * rcp_fall / 2^XW)`, with `rcp_fall` in the same format.
- R3: A raw next state of `2^XW` or more saturates to all ones (XW bits). For example, `x == g` with an exact reciprocal gives all ones.
- R4: The LFSR is a left-shifting Fibonacci register. Its output bit is the top stage, bit LW-1. The bit shifted into bit 0 is the parity of `state & TAPS`. Bit 0 of the fed-back state is the raw bit 0 XOR the output bit. The LFSR advances exactly once per accepted byte.
- R5: The keystream byte is bits 7..0 of the perturbed state, and the output byte is the input byte XOR that keystream byte. The first byte accepted after a load uses the first map step from `x0`.
- R6: An all-zero LFSR seed is replaced by the value 1 at load, so the register is never zero.
- R7: After reset or in the cycle after `key_load`, `out_valid` is 0. Any pending output byte is dropped. `in_ready` is 0 while `key_load` is high.
- R8: While `out_valid && !out_ready`, `out_data` and `out_valid` hold, `in_ready` is 0, and neither the map state nor the LFSR advances.
- R9: Loading the same key and feeding ciphertext bytes back in returns the original plaintext in order.
- R10: An accepted byte appears on `out_valid` in the next cycle. With `out_ready` held high, `in_ready` stays high and one byte passes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Load strobe for all key fields |
| key_gamma | input | XW | Map breakpoint fraction |
| key_x0 | input | XW | Starting map state fraction |
| key_rcp_rise | input | XW+IW | Reciprocal of the breakpoint, IW.XW unsigned |
| key_rcp_fall | input | XW+IW | Reciprocal of one minus the breakpoint, IW.XW unsigned |
| key_seed | input | LW | LFSR starting state |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Core accepts an input byte |
| in_data | input | BW | Plaintext or ciphertext byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |
| out_data | output | BW | Input byte XOR keystream byte |

## Verification
The bench builds a 16-bit map with a 7-stage LFSR and keeps an arithmetic model of the map, its saturation and the LFSR. It streams hundreds of pseudo-random bytes under several breakpoints: centred, low, high and near both ends. This drives both sides of the map and the saturation path through long orbits. Hand-picked starting states exercise each side and the `x == g` edge on the very first byte, and separate a wrong branch, a missing perturbation and a missing clamp. Irregular back-pressure, a load while an output byte is pending, a zero seed, and a reload followed by decryption of the captured ciphertext separate stall, flush, seed-guard and key-reproducibility faults.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
   // which side of the tent map the current state falls on
   typedef enum logic {
      BR_RISE = 1'b0,
      BR_FALL = 1'b1
   } cmc_branch_e;

   localparam int CMC_BYTE_W = 8;
endpackage

// File: rtl/cmc_lfsr.sv
module cmc_lfsr #(
   parameter int             LW   = 61,
   parameter logic [LW-1:0]  TAPS = 61'h1800_3000_0000_0000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [LW-1:0] seed_i,
   input  logic          step_i,
   output logic          bit_o,
   output logic [LW-1:0] state_o
);
   localparam logic [LW-1:0] ONE = LW'(1);

   generate
      if (LW < 2) begin : g_bad_len
         $error("cmc_lfsr: LW must be at least 2");
      end
      if (TAPS[LW-1] == 1'b0) begin : g_bad_taps
         $error("cmc_lfsr: TAPS must include the top stage");
      end
   endgenerate

   logic [LW-1:0] state_q;
   logic [LW-1:0] seed_safe;
   logic          feedback;

   assign seed_safe = (seed_i == '0) ? ONE : seed_i;
   assign feedback  = ^(state_q & TAPS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ONE;
      end else if (load_i) begin
         state_q <= seed_safe;
      end else if (step_i) begin
         state_q <= {state_q[LW-2:0], feedback};
      end
   end

   assign bit_o   = state_q[LW-1];
   assign state_o = state_q;
endmodule

// File: rtl/cmc_tent_step.sv
module cmc_tent_step
   import cmc_pkg::*;
#(
   parameter int XW        = 64,
   parameter int IW        = 16,
   parameter bit SHARE_MUL = 1'b1,
   localparam int RW       = XW + IW
) (
   input  logic [XW-1:0] x_i,
   input  logic [XW-1:0] gamma_i,
   input  logic [RW-1:0] rcp_rise_i,
   input  logic [RW-1:0] rcp_fall_i,
   input  logic          flip_i,
   output logic [XW-1:0] x_next_o
);
   localparam int AW = XW + 1;   // operand width holding 1-x exactly
   localparam int PW = AW + RW;  // full product width
   localparam int QW = PW - XW;  // product scaled back to XW fraction bits

   cmc_branch_e   side;
   logic [AW-1:0] x_ext;
   logic [AW-1:0] x_comp;
   logic [PW-1:0] prod;
   logic [QW-1:0] quot;
   logic          over;
   logic [XW-1:0] raw;
   logic          unused_lo;

   assign side   = (x_i <= gamma_i) ? BR_RISE : BR_FALL;
   assign x_ext  = {1'b0, x_i};
   assign x_comp = {1'b1, {XW{1'b0}}} - x_ext;

   generate
      if (SHARE_MUL) begin : g_one_mul
         // operands selected first, one multiplier
         logic [AW-1:0] op_a;
         logic [RW-1:0] op_b;
         assign op_a = (side == BR_RISE) ? x_ext : x_comp;
         assign op_b = (side == BR_RISE) ? rcp_rise_i : rcp_fall_i;
         assign prod = {{RW{1'b0}}, op_a} * {{AW{1'b0}}, op_b};
      end else begin : g_two_mul
         // both sides multiplied in parallel with the compare
         logic [PW-1:0] prod_rise;
         logic [PW-1:0] prod_fall;
         assign prod_rise = {{RW{1'b0}}, x_ext}  * {{AW{1'b0}}, rcp_rise_i};
         assign prod_fall = {{RW{1'b0}}, x_comp} * {{AW{1'b0}}, rcp_fall_i};
         assign prod      = (side == BR_RISE) ? prod_rise : prod_fall;
      end
   endgenerate

   assign quot      = prod[PW-1:XW];
   assign unused_lo = ^prod[XW-1:0];
   assign over      = |quot[QW-1:XW];
   assign raw       = over ? {XW{1'b1}} : quot[XW-1:0];
   assign x_next_o  = {raw[XW-1:1], raw[0] ^ flip_i};
endmodule

// File: rtl/cmc_out_stage.sv
module cmc_out_stage #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush_i,
   input  logic          push_i,
   input  logic [DW-1:0] data_i,
   output logic          room_o,
   output logic          valid_o,
   input  logic          take_i,
   output logic [DW-1:0] data_o
);
   logic          valid_q;
   logic [DW-1:0] data_q;

   assign room_o = !valid_q || take_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (flush_i) begin
         valid_q <= 1'b0;
      end else if (push_i) begin
         valid_q <= 1'b1;
         data_q  <= data_i;
      end else if (take_i) begin
         valid_q <= 1'b0;
      end
   end

   assign valid_o = valid_q;
   assign data_o  = data_q;
endmodule

// File: rtl/chaos_stream_cipher.sv
module chaos_stream_cipher
   import cmc_pkg::*;
#(
   parameter int            XW        = 64,
   parameter int            IW        = 16,
   parameter int            LW        = 61,
   parameter logic [LW-1:0] TAPS      = 61'h1800_3000_0000_0000,
   parameter int            BW        = CMC_BYTE_W,
   parameter bit            SHARE_MUL = 1'b1,
   localparam int           RW        = XW + IW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          key_load,
   input  logic [XW-1:0] key_gamma,
   input  logic [XW-1:0] key_x0,
   input  logic [RW-1:0] key_rcp_rise,
   input  logic [RW-1:0] key_rcp_fall,
   input  logic [LW-1:0] key_seed,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [BW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [BW-1:0] out_data
);
   generate
      if (XW <= BW) begin : g_bad_xw
         $error("chaos_stream_cipher: XW must exceed the byte width");
      end
      if (IW < 1) begin : g_bad_iw
         $error("chaos_stream_cipher: IW must be at least 1");
      end
   endgenerate

   logic [XW-1:0] x_q;
   logic [XW-1:0] gamma_q;
   logic [RW-1:0] rcp_rise_q;
   logic [RW-1:0] rcp_fall_q;
   logic [XW-1:0] x_next;
   logic [LW-1:0] lfsr_state;
   logic          lfsr_bit;
   logic          stage_room;
   logic          accept;
   logic [BW-1:0] ks_byte;

   assign in_ready = !key_load && stage_room;
   assign accept   = in_valid && in_ready;
   assign ks_byte  = x_next[BW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q        <= '0;
         gamma_q    <= '0;
         rcp_rise_q <= '0;
         rcp_fall_q <= '0;
      end else if (key_load) begin
         x_q        <= key_x0;
         gamma_q    <= key_gamma;
         rcp_rise_q <= key_rcp_rise;
         rcp_fall_q <= key_rcp_fall;
      end else if (accept) begin
         x_q        <= x_next;
      end
   end

   cmc_tent_step #(
      .XW        (XW),
      .IW        (IW),
      .SHARE_MUL (SHARE_MUL)
   ) u_step (
      .x_i        (x_q),
      .gamma_i    (gamma_q),
      .rcp_rise_i (rcp_rise_q),
      .rcp_fall_i (rcp_fall_q),
      .flip_i     (lfsr_bit),
      .x_next_o   (x_next)
   );

   cmc_lfsr #(
      .LW   (LW),
      .TAPS (TAPS)
   ) u_lfsr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (key_load),
      .seed_i  (key_seed),
      .step_i  (accept),
      .bit_o   (lfsr_bit),
      .state_o (lfsr_state)
   );

   cmc_out_stage #(
      .DW (BW)
   ) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush_i (key_load),
      .push_i  (accept),
      .data_i  (in_data ^ ks_byte),
      .room_o  (stage_room),
      .valid_o (out_valid),
      .take_i  (out_ready),
      .data_o  (out_data)
   );
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
   parameter int LW = 61,
   parameter int BW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          key_load,
   input logic          in_valid,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [BW-1:0] out_data,
   input logic [LW-1:0] lfsr_state
);
   // R8: a blocked output byte is held unchanged
   a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready && !key_load |=> out_valid && $stable(out_data));

   // R8: no byte is taken while the output is blocked
   a_r8_in_block: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);

   // R8: the LFSR does not move without an accepted byte or a load
   a_r8_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !key_load && !(in_valid && in_ready) |=> $stable(lfsr_state));

   // R4: the LFSR moves on every accepted byte
   a_r4_lfsr_step: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> lfsr_state != $past(lfsr_state));

   // R6: the LFSR never holds the all-zero state
   a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

   // R7: no input is taken during a load, and the output is flushed
   a_r7_load_ready: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |-> !in_ready);
   a_r7_load_flush: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> !out_valid);

   // R10: an accepted byte is presented on the next cycle
   a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready |=> out_valid);
endmodule

bind chaos_stream_cipher cmc_checker #(
   .LW (LW),
   .BW (BW)
) u_cmc_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .key_load   (key_load),
   .in_valid   (in_valid),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_data   (out_data),
   .lfsr_state (lfsr_state)
);

// File: tb/chaos_stream_cipher_bench.sv
`timescale 1ns/1ps
module chaos_stream_cipher_bench;
   localparam int XW = 16;
   localparam int IW = 8;
   localparam int LW = 7;
   localparam int RW = XW + IW;
   localparam logic [LW-1:0] TAPS = 7'h60;   // stages 7 and 6

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          key_load = 1'b0;
   logic [XW-1:0] key_gamma = '0;
   logic [XW-1:0] key_x0 = '0;
   logic [RW-1:0] key_rcp_rise = '0;
   logic [RW-1:0] key_rcp_fall = '0;
   logic [LW-1:0] key_seed = '0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [7:0]    in_data = '0;
   logic          out_valid;
   logic          out_ready = 1'b0;
   logic [7:0]    out_data;

   always #2.5 clk = ~clk;

   chaos_stream_cipher #(
      .XW (XW), .IW (IW), .LW (LW), .TAPS (TAPS), .BW (8), .SHARE_MUL (1'b1)
   ) u_chaos_stream_cipher (
      .clk (clk), .rst_n (rst_n), .key_load (key_load),
      .key_gamma (key_gamma), .key_x0 (key_x0),
      .key_rcp_rise (key_rcp_rise), .key_rcp_fall (key_rcp_fall),
      .key_seed (key_seed),
      .in_valid (in_valid), .in_ready (in_ready), .in_data (in_data),
      .out_valid (out_valid), .out_ready (out_ready), .out_data (out_data)
   );

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;
   string cur_tag = "R5";

   // reference model state
   longint unsigned mx, mg, mrise, mfall;
   logic [6:0] ml;

   // expected stream bookkeeping
   logic [7:0] exp_q [512];
   logic [7:0] pt_q  [512];
   logic [7:0] ct_q  [512];
   logic [7:0] pt_keep [512];
   logic [7:0] ct_keep [512];
   int wr = 0;
   int rd = 0;
   bit dec_mode = 1'b0;
   bit prev_stall = 1'b0;
   bit prev_accept = 1'b0;
   bit prev_load = 1'b0;
   logic [7:0] prev_data = '0;
   logic [31:0] rng = 32'h1234_5678;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
      end
   endtask

   function automatic logic [7:0] rnd8();
      rng = rng * 32'd1103515245 + 32'd12345;
      return rng[23:16];
   endfunction

   // one map step per R1..R4: multiply, clamp, perturb, shift LFSR
   function automatic logic [7:0] model_step();
      longint unsigned p, q;
      if (mx <= mg) p = mx * mrise;
      else          p = (64'd65536 - mx) * mfall;
      q = p >> 16;
      if (q > 64'd65535) q = 64'd65535;
      q = q ^ {63'd0, ml[6]};
      ml = {ml[5:0], ml[6] ^ ml[5]};
      mx = q;
      return q[7:0];
   endfunction

   task automatic evaluate();
      if (prev_stall)
         chk(out_valid && out_data == prev_data, "R8 hold", int'(out_data), int'(prev_data));
      if (prev_accept)
         chk(out_valid, "R10 latency", int'(out_valid), 1);
      if (prev_load)
         chk(!out_valid, "R7 flush", int'(out_valid), 0);
      if (out_valid && !out_ready)
         chk(!in_ready, "R8 block", int'(in_ready), 0);
      if (key_load) begin
         chk(!in_ready, "R7 ready", int'(in_ready), 0);
         mx = 64'(key_x0); mg = 64'(key_gamma);
         mrise = 64'(key_rcp_rise); mfall = 64'(key_rcp_fall);
         ml = (key_seed == '0) ? 7'd1 : key_seed;
         rd = 0; wr = 0;
      end else begin
         if (out_valid && out_ready) begin
            chk(rd < wr && out_data == exp_q[rd], cur_tag, int'(out_data), int'(exp_q[rd]));
            ct_q[rd] = out_data;
            rd++;
         end
         if (in_valid && in_ready) begin
            pt_q[wr] = in_data;
            if (dec_mode) exp_q[wr] = pt_keep[wr];
            else          exp_q[wr] = in_data ^ model_step();
            wr++;
         end
      end
      prev_stall  = out_valid && !out_ready && !key_load;
      prev_data   = out_data;
      prev_accept = in_valid && in_ready;
      prev_load   = key_load;
   endtask

   task automatic step(input logic v, input logic [7:0] d, input logic rdy, input logic ld);
      @(negedge clk);
      in_valid = v; in_data = d; out_ready = rdy; key_load = ld;
      #1;
      evaluate();
   endtask

   task automatic do_load(input logic [15:0] g, input logic [15:0] x0,
                          input logic [6:0] seed, input logic rdy);
      longint unsigned one = 64'd1 << 32;
      key_gamma = g; key_x0 = x0; key_seed = seed;
      key_rcp_rise = RW'(one / 64'(g));
      key_rcp_fall = RW'(one / (64'd65536 - 64'(g)));
      step(1'b0, 8'h00, rdy, 1'b1);
   endtask

   task automatic drain();
      for (int k = 0; k < 8; k++) begin
         if (rd < wr || out_valid) step(1'b0, 8'h00, 1'b1, 1'b0);
      end
      chk(rd == wr, "R10 drain", rd, wr);
   endtask

   // bp: 0 = always ready, 1 = irregular back-pressure and gaps; src_ct feeds kept ciphertext
   task automatic stream(input int n, input bit bp, input bit src_ct);
      int sent = 0;
      int guard = 0;
      while (sent < n && guard < 4 * n + 16) begin
         logic v, r;
         logic [7:0] d;
         v = bp ? (rnd8() < 8'd200) : 1'b1;
         r = bp ? (rnd8() < 8'd150) : 1'b1;
         d = src_ct ? ct_keep[wr] : rnd8();
         if (!bp && wr > 0) chk(in_ready, "R10 throughput", int'(in_ready), 1);
         step(v, d, r, 1'b0);
         if (prev_accept) sent++;
         guard++;
      end
      drain();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(!out_valid, "R7 reset valid", int'(out_valid), 0);
      rst_n = 1'b1;
      step(1'b0, 8'h00, 1'b1, 1'b0);
      chk(in_ready, "R7 reset ready", int'(in_ready), 1);

      // R1 and R4: rising side, perturbation flips bit 0
      cur_tag = "R1";
      do_load(16'h8000, 16'h1000, 7'h40, 1'b0);
      step(1'b1, 8'hA5, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(out_valid && out_data == 8'hA4, "R1 R4 first byte", int'(out_data), 8'hA4);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      drain();

      // R2: falling side
      cur_tag = "R2";
      do_load(16'h8000, 16'hC000, 7'h01, 1'b0);
      step(1'b1, 8'h3C, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(out_valid && out_data == 8'h3C, "R2 first byte", int'(out_data), 8'h3C);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      drain();

      // R3: x equal to the breakpoint clamps to all ones
      cur_tag = "R3";
      do_load(16'h8000, 16'h8000, 7'h01, 1'b0);
      step(1'b1, 8'h00, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(out_valid && out_data == 8'hFF, "R3 clamp", int'(out_data), 8'hFF);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      stream(40, 1'b0, 1'b0);

      // R5/R1/R2/R3: long streams across breakpoints, no back-pressure
      cur_tag = "R5 stream";
      do_load(16'h8000, 16'h3A71, 7'h5A, 1'b1);  stream(300, 1'b0, 1'b0);
      do_load(16'h4000, 16'h9E37, 7'h33, 1'b1);  stream(300, 1'b0, 1'b0);
      do_load(16'hC000, 16'h1234, 7'h7F, 1'b1);  stream(300, 1'b0, 1'b0);
      do_load(16'h0300, 16'h0100, 7'h2C, 1'b1);  stream(200, 1'b0, 1'b0);
      do_load(16'hFD00, 16'hFE80, 7'h11, 1'b1);  stream(200, 1'b0, 1'b0);

      // R8: irregular back-pressure and input gaps
      cur_tag = "R8 stream";
      do_load(16'h6A3D, 16'h5151, 7'h46, 1'b1);  stream(300, 1'b1, 1'b0);

      // R6: zero seed behaves as seed 1
      cur_tag = "R6 stream";
      do_load(16'h8000, 16'h8000, 7'h00, 1'b0);
      step(1'b1, 8'h00, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(out_valid && out_data == 8'hFF, "R6 zero seed", int'(out_data), 8'hFF);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      stream(150, 1'b0, 1'b0);

      // R7: load while an output byte is pending
      cur_tag = "R7 stream";
      do_load(16'h8000, 16'h2222, 7'h19, 1'b0);
      step(1'b1, 8'h55, 1'b0, 1'b0);
      step(1'b0, 8'h00, 1'b0, 1'b0);
      chk(out_valid, "R7 pending", int'(out_valid), 1);
      do_load(16'h5555, 16'h7777, 7'h62, 1'b0);
      step(1'b0, 8'h00, 1'b1, 1'b0);
      stream(60, 1'b0, 1'b0);

      // R9: encrypt, reload same key, decrypt
      cur_tag = "R9 encrypt";
      do_load(16'hA1B2, 16'h0F0F, 7'h3D, 1'b1);
      stream(100, 1'b1, 1'b0);
      for (int i = 0; i < 100; i++) begin
         pt_keep[i] = pt_q[i];
         ct_keep[i] = ct_q[i];
      end
      cur_tag = "R9 decrypt";
      dec_mode = 1'b1;
      do_load(16'hA1B2, 16'h0F0F, 7'h3D, 1'b1);
      stream(100, 1'b1, 1'b1);
      dec_mode = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule